// File: doc/BRIEF.md
# Serially Loaded Truth-Table Word Multiplexer

This block picks one of four data words and passes it to its output. It does not steer a select line through a gate tree. Each output bit is a 16-entry truth table. The four data bits of that lane form the address into the table, and the output is the bit stored at that address. Once the table holds the right contents, the data path is a single lookup.

Changing the selection means rewriting every table. A shared programmer latches a 2-bit select code and an enable, and forms the matching 16-bit pattern. It then shifts that pattern into all lane tables at once, one bit per clock, most-significant bit first, and holds `busy` high while it does so. When the last bit is in, it pulses `done`.

A reload costs 16 clocks. The block therefore suits selections that are fixed or that change rarely. There is no streaming data interface: data words are plain combinational inputs. The load request is a single-cycle control strobe, and there is no back-pressure.

Top module: `serial_lut_mux`

## Requirements
- R1: After a completed load with the enable set, `mux_out` equals the data word picked by the select code, for every combination of the four lane bits.
- R2: After a completed load with the enable clear, `mux_out` is all zeros whatever the data inputs hold. The table pattern for this case is 16'h0000.
- R3: Select code encodings:
  - 0 picks `din_a`, with pattern 16'hAAAA.
  - 1 picks `din_b`, with pattern 16'hCCCC.
  - 2 picks `din_c`, with pattern 16'hF0F0.
  - 3 picks `din_d`, with pattern 16'hFF00.
  - The table address of lane i is {din_d[i], din_c[i], din_b[i], din_a[i]}.
- R4: A request sampled with `busy` low raises `busy` in the next cycle and keeps it high for exactly 16 cycles.
- R5: `done` is high for exactly one cycle: the first cycle after `busy` falls.
- R6: A request sampled while `busy` is high is ignored. The load in progress neither restarts nor lengthens, and the selection that results is the one first requested.
- R7: While `busy` is high, `out_valid` is low and `mux_out` is forced to zero. Otherwise `out_valid` is high.
- R8: After reset, every table is empty, which acts as the disabled selection. `busy` and `done` are low and `out_valid` is high.
- R9: A request presented in the cycle where `done` is high is accepted, and starts a new 16-cycle load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Load strobe, sampled on a rising edge |
| cfg_sel | input | 2 | Select code for the new selection |
| cfg_en | input | 1 | Enable for the new selection; 0 forces the output to zero |
| busy | output | 1 | High while the tables are being shifted |
| done | output | 1 | One-cycle pulse after a load completes |
| din_a | input | WIDTH | Data word 0 (table address bit 0) |
| din_b | input | WIDTH | Data word 1 (table address bit 1) |
| din_c | input | WIDTH | Data word 2 (table address bit 2) |
| din_d | input | WIDTH | Data word 3 (table address bit 3) |
| mux_out | output | WIDTH | Selected word, per-lane table lookup |
| out_valid | output | 1 | High when no load is in progress |

## Verification
Each selection is tried with sixteen data patterns. In each pattern, every lane sees a different 4-bit address, rotating, so that over the set each lane sees all sixteen addresses. This tells a correct table apart from one with a wrong pattern, a swapped address bit or a bit-reversed shift order.

The patterns are rerun after a disabled load, to show that the zero table blocks every input. They are also rerun after a request made in mid-load, to show that the first selection survives the ignored request. Load timing is measured cycle by cycle, including a request placed in the `done` cycle.

// File: rtl/lutmux_pkg.sv
package lutmux_pkg;
  localparam int unsigned TBL_AW    = 4;
  localparam int unsigned TBL_DEPTH = 1 << TBL_AW;
  localparam int unsigned CNT_W     = $clog2(TBL_DEPTH);

  typedef logic [TBL_DEPTH-1:0] tbl_pat_t;
  typedef logic [1:0]           sel_code_t;

  typedef enum logic [1:0] {
    PICK_A = 2'd0,
    PICK_B = 2'd1,
    PICK_C = 2'd2,
    PICK_D = 2'd3
  } pick_e;
endpackage

// File: rtl/lutmux_pattern_gen.sv
// Forms the truth-table image for a select code: entry j is set when
// address bit <sel> of j is 1 and the selection is enabled.
module lutmux_pattern_gen
  import lutmux_pkg::*;
(
  input  logic      [1:0] sel,
  input  logic            en,
  output tbl_pat_t        pattern
);
  for (genvar j = 0; j < TBL_DEPTH; j++) begin : g_entry
    localparam logic [TBL_AW-1:0] ADDR = TBL_AW'(j);
    assign pattern[j] = en & ADDR[sel];
  end
endmodule

// File: rtl/lutmux_loader.sv
// Shared programmer: latches a pattern and shifts it out MSB first over
// TBL_DEPTH cycles, then pulses done.
module lutmux_loader
  import lutmux_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  tbl_pat_t pat_in,
  output logic     busy,
  output logic     done,
  output logic     shift_en,
  output logic     ser_bit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TBL_DEPTH - 1);

  tbl_pat_t         pat_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      pat_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          pat_q <= pat_in;
          cnt_q <= '0;
          busy  <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign shift_en = busy;
  assign ser_bit  = pat_q[LAST - cnt_q];

  // R4: an accepted request starts a load from the first position
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (busy && cnt_q == '0));

  // R4: the final shift ends the load and raises done
  a_r4_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == LAST) |=> (!busy && done));

  // R5: done only follows the fall of busy
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R6: the latched pattern cannot change mid-load
  a_r6_pattern_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != LAST) |=> $stable(pat_q));
endmodule

// File: rtl/lutmux_lane.sv
// One lane: a TBL_DEPTH-bit shift register read as a truth table.
module lutmux_lane
  import lutmux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              ser_bit,
  input  logic [TBL_AW-1:0] addr,
  output logic              q
);
  tbl_pat_t tbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tbl_q <= '0;
    else if (shift_en) tbl_q <= {tbl_q[TBL_DEPTH-2:0], ser_bit};
  end

  assign q = tbl_q[addr];

  // R2/R6: table contents only move while the programmer shifts
  a_r6_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(shift_en) |-> $stable(tbl_q));
endmodule

// File: rtl/serial_lut_mux.sv
module serial_lut_mux
  import lutmux_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  input  logic [1:0]       cfg_sel,
  input  logic             cfg_en,
  output logic             busy,
  output logic             done,
  input  logic [WIDTH-1:0] din_a,
  input  logic [WIDTH-1:0] din_b,
  input  logic [WIDTH-1:0] din_c,
  input  logic [WIDTH-1:0] din_d,
  output logic [WIDTH-1:0] mux_out,
  output logic             out_valid
);
  tbl_pat_t         pat_w;
  logic             shift_w;
  logic             ser_w;
  logic [WIDTH-1:0] raw_w;

  lutmux_pattern_gen u_pat (
    .sel     (cfg_sel),
    .en      (cfg_en),
    .pattern (pat_w)
  );

  lutmux_loader u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (cfg_req),
    .pat_in   (pat_w),
    .busy     (busy),
    .done     (done),
    .shift_en (shift_w),
    .ser_bit  (ser_w)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    lutmux_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_w),
      .ser_bit  (ser_w),
      .addr     ({din_d[i], din_c[i], din_b[i], din_a[i]}),
      .q        (raw_w[i])
    );
  end

  assign out_valid = ~busy;
  assign mux_out   = busy ? '0 : raw_w;

  // R7: no data escapes while tables are in motion
  a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!out_valid && mux_out == '0));

  // R5: done never overlaps a load
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/serial_lut_mux_tb_top.sv
`timescale 1ns/1ps
module serial_lut_mux_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_req = 1'b0;
  logic [1:0]   cfg_sel = 2'd0;
  logic         cfg_en = 1'b0;
  logic         busy, done, out_valid;
  logic [W-1:0] din_a = '0, din_b = '0, din_c = '0, din_d = '0;
  logic [W-1:0] mux_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_lut_mux #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_sel(cfg_sel),
    .cfg_en(cfg_en), .busy(busy), .done(done), .din_a(din_a),
    .din_b(din_b), .din_c(din_c), .din_d(din_d), .mux_out(mux_out),
    .out_valid(out_valid)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick(input logic [1:0] s, input logic en);
    if (!en) return '0;
    case (s)
      2'd0: return din_a;
      2'd1: return din_b;
      2'd2: return din_c;
      default: return din_d;
    endcase
  endfunction

  // Request at one edge, then count busy cycles and check done (R4, R5)
  task automatic do_load(input logic [1:0] s, input logic en,
                         input bit extra_req);
    int bcnt = 0;
    @(negedge clk);
    cfg_sel = s; cfg_en = en; cfg_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
    while (busy && bcnt < 40) begin
      check("R7 out_valid low while busy", out_valid, 0);
      check("R7 output zero while busy", mux_out, 0);
      if (extra_req && bcnt == 5) begin
        cfg_sel = s + 2'd1; cfg_en = ~en; cfg_req = 1'b1;  // R6
      end else begin
        cfg_req = 1'b0;
      end
      bcnt++;
      @(negedge clk);
    end
    cfg_req = 1'b0;
    check("R4 busy length", bcnt, 16);
    check("R5 done after busy", done, 1);
    check("R7 out_valid after load", out_valid, 1);
  endtask

  // Sixteen rotating address patterns per lane (R1, R2, R3)
  task automatic sweep(input string tag, input logic [1:0] s, input logic en);
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < W; i++) begin
        logic [3:0] ad = 4'(k + i);
        din_a[i] = ad[0]; din_b[i] = ad[1];
        din_c[i] = ad[2]; din_d[i] = ad[3];
      end
      #2;
      check(tag, mux_out, pick(s, en));
    end
  endtask

  task automatic t_reset;
    check("R8 busy at reset", busy, 0);
    check("R8 done at reset", done, 0);
    check("R8 out_valid at reset", out_valid, 1);
    din_a = '1; din_b = '1; din_c = '1; din_d = '1;
    #2;
    check("R8 empty table gives zero", mux_out, 0);
  endtask

  task automatic t_each_select;
    for (int s = 0; s < 4; s++) begin
      do_load(2'(s), 1'b1, 1'b0);
      @(negedge clk);
      check("R5 done is one cycle", done, 0);
      sweep("R1/R3 lookup of selected word", 2'(s), 1'b1);
    end
  endtask

  task automatic t_disabled;
    do_load(2'd2, 1'b0, 1'b0);
    sweep("R2 disabled output zero", 2'd2, 1'b0);
  endtask

  task automatic t_ignored_req;
    do_load(2'd1, 1'b1, 1'b1);
    @(negedge clk);
    check("R6 no restart after ignored request", busy, 0);
    sweep("R6 first selection kept", 2'd1, 1'b1);
  endtask

  task automatic t_back_to_back;
    int bcnt = 0;
    do_load(2'd0, 1'b1, 1'b0);
    // now in the done cycle: present a new request (R9)
    cfg_sel = 2'd3; cfg_en = 1'b1; cfg_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
    while (busy && bcnt < 40) begin bcnt++; @(negedge clk); end
    check("R9 request in done cycle accepted", bcnt, 16);
    sweep("R9 new selection active", 2'd3, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_each_select();
    t_disabled();
    t_ignored_req();
    t_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule